// File: doc/BRIEF.md
# SPI Memory Write-Protection Controller

This block holds the command decoder and write-protection logic for a 256K x 8 serial memory with a mode-0 SPI slave port. It runs on a fast local clock, resynchronises the SPI pins, and recognises six opcodes: write enable, write disable, status read, status write, data read and data write. It keeps a small status register and a write-enable latch. It drives a one-cycle byte-write strobe, an address and write data into an external memory with a registered read port. It also returns read data to the host most-significant bit first.

Protection works in tiers. First, a latch must be armed before any write, and every completed write command clears it again. Second, two block-protect bits fence off the top quarter, the top half or the whole array. Third, a lock bit in the status register lets the active-low protect pin freeze those two bits. Because writes finish at once, the ready/busy bit is never set. The SPI clock must be slow enough that each half period spans several local clock cycles.

Top module: `spi_wp_ctrl`

## Requirements
- R1: The status byte reads as {lock bit, 1, 0, 0, BP1, BP0, latch, 0} from bit 7 down to bit 0. A status write changes only bit 7 and bits 3:2. The values written to bits 6, 5, 4, 1 and 0 have no effect.
- R2: The write-enable latch is set by opcode 06h and cleared by opcode 04h. Either action takes place only when chip select rises after the full opcode byte has arrived.
- R3: A status write (opcode 01h followed by one data byte) clears the latch when chip select rises. This happens whether or not the register was updated.
- R4: A status write updates the lock bit and BP1:BP0 only when the latch is set and it is not the case that the lock bit is 1 while wp_n is low. When the lock bit is 0, wp_n has no effect.
- R5: BP1:BP0 = 00 protects no address. 01 protects 30000h to 3FFFFh. 10 protects 20000h to 3FFFFh. 11 protects every address.
- R6: A data byte of a write command (opcode 02h) reaches memory only if the latch is set and that byte's own address lies outside the protected range.
- R7: Opcode 05h returns the status byte in every following byte slot, and bit 0 always reads 0.
- R8: Read (03h) and write (02h) take three address bytes, and only the low 18 bits are used. The address advances by one after each data byte and wraps from 3FFFFh to 00000h.
- R9: Mode 0 timing applies: input is sampled on the rising SCK edge and output changes on the falling edge, MSB first. spi_miso_oe is low while chip select is high.
- R10: A command that is cut short performs no action. A write command that carried at least one data byte clears the latch when chip select rises.
- R11: An unknown opcode causes every byte that follows it to be ignored until chip select goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | local clock |
| rst_n | input | 1 | active-low asynchronous reset |
| spi_cs_n | input | 1 | chip select, active low |
| spi_sck | input | 1 | SPI clock, mode 0 |
| spi_mosi | input | 1 | serial data in |
| wp_n | input | 1 | active-low hardware write-protect pin |
| spi_miso | output | 1 | serial data out |
| spi_miso_oe | output | 1 | output enable for spi_miso |
| mem_we | output | 1 | one-cycle byte write strobe |
| mem_addr | output | 18 | memory byte address |
| mem_wdata | output | 8 | memory write data |
| mem_rdata | input | 8 | memory read data, valid one clock after mem_addr |

## Verification
The hardest case to reach from the ports is a status write that arrives with the latch set while the lock bit is 1 and wp_n is low. The write must be refused, yet it must still clear the latch. Reaching it takes three steps in order: first program the lock bit, then lower the pin, then re-arm the latch. Directed sequences do exactly that. Random sequences also toggle wp_n and bias status writes toward setting the lock bit, so locked and unlocked writes mix with data writes that straddle the 20000h, 30000h and wrap boundaries.

// File: rtl/spi_wp_pkg.sv
package spi_wp_pkg;
   localparam logic [7:0] OP_WREN = 8'h06;
   localparam logic [7:0] OP_WRDI = 8'h04;
   localparam logic [7:0] OP_RDSR = 8'h05;
   localparam logic [7:0] OP_WRSR = 8'h01;
   localparam logic [7:0] OP_READ = 8'h03;
   localparam logic [7:0] OP_WRITE = 8'h02;

   typedef enum logic [2:0] {
      ST_OPC, ST_ADDR, ST_RD, ST_WR, ST_STAT, ST_SRW, ST_HOLD
   } phase_t;

   typedef enum logic [2:0] {
      PD_NONE, PD_WREN, PD_WRDI, PD_WRSR, PD_WRITE
   } pend_t;
endpackage

// File: rtl/spi_wp_sync.sv
module spi_wp_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH = 1,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("spi_wp_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_wp_range.sv
module spi_wp_range #(
   parameter int ADDR_W = 18
) (
   input  logic [1:0]        bp,
   input  logic [ADDR_W-1:0] addr,
   output logic              locked
);
   generate
      if (ADDR_W < 2) begin : g_bad
         $error("spi_wp_range: ADDR_W must be at least 2");
      end
   endgenerate

   logic [1:0] top2;
   assign top2 = addr[ADDR_W-1 -: 2];

   always_comb begin
      unique case (bp)
         2'b00: locked = 1'b0;
         2'b01: locked = (top2 == 2'b11);
         2'b10: locked = top2[1];
         default: locked = 1'b1;
      endcase
   end
endmodule

// File: rtl/spi_wp_status.sv
module spi_wp_status (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       set_wel,
   input  logic       clr_wel,
   input  logic       sr_load,
   input  logic [7:0] sr_data,
   input  logic       wp_pin_n,
   output logic       wel,
   output logic [1:0] bp,
   output logic [7:0] status
);
   logic wpen;
   logic sr_ok;

   assign sr_ok = wel && !(wpen && !wp_pin_n);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel <= 1'b0;
         wpen <= 1'b0;
         bp <= 2'b00;
      end else begin
         if (set_wel) wel <= 1'b1;
         else if (clr_wel) wel <= 1'b0;
         if (sr_load && sr_ok) begin
            wpen <= sr_data[7];
            bp <= sr_data[3:2];
         end
      end
   end

   assign status = {wpen, 1'b1, 2'b00, bp, wel, 1'b0};

   // R4: protect bits only move after the latch was armed
   a_r4_bp_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(bp) |-> $past(wel));
   // R2: latch rises only from the enable command
   a_r2_wel_rise_src: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wel) |-> $past(set_wel));
   // R3: a finished status write leaves the latch clear
   a_r3_wrsr_clears: assert property (@(posedge clk) disable iff (!rst_n)
      sr_load |=> !wel);
endmodule

// File: rtl/spi_wp_ctrl.sv
module spi_wp_ctrl
   import spi_wp_pkg::*;
#(
   parameter int ADDR_W = 18,
   parameter int ADDR_BYTES = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_cs_n,
   input  logic              spi_sck,
   input  logic              spi_mosi,
   input  logic              wp_n,
   output logic              spi_miso,
   output logic              spi_miso_oe,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   input  logic [7:0]        mem_rdata
);
   localparam int BC_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
   localparam logic [BC_W-1:0] BC_LAST = BC_W'(ADDR_BYTES - 1);

   generate
      if (ADDR_W <= 8 || ADDR_W > 8 * ADDR_BYTES) begin : g_bad
         $error("spi_wp_ctrl: ADDR_W must exceed 8 and fit in ADDR_BYTES");
      end
   endgenerate

   logic cs_s, sck_s, mosi_s, wp_s;
   spi_wp_sync #(.STAGES(SYNC_STAGES), .WIDTH(4), .RST_VAL(4'b1001)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({spi_cs_n, spi_sck, spi_mosi, wp_n}),
      .q({cs_s, sck_s, mosi_s, wp_s})
   );

   logic sck_q, cs_q;
   logic sck_rise, sck_fall, cs_rise;
   assign sck_rise = !cs_s && sck_s && !sck_q;
   assign sck_fall = !cs_s && !sck_s && sck_q;
   assign cs_rise = cs_s && !cs_q;

   phase_t            phase;
   pend_t             pend;
   logic [2:0]        bit_cnt;
   logic [6:0]        rx_sr;
   logic [BC_W-1:0]   byte_cnt;
   logic              rd_cmd;
   logic              adv;
   logic [ADDR_W-1:0] addr;
   logic [7:0]        sr_buf;
   logic [7:0]        tx_sr;
   logic [7:0]        rx_byte;
   logic              byte_done;
   logic              locked;
   logic              wel;
   logic [1:0]        bp;
   logic [7:0]        status;

   assign rx_byte = {rx_sr, mosi_s};
   assign byte_done = sck_rise && (bit_cnt == 3'd7);

   spi_wp_range #(.ADDR_W(ADDR_W)) u_range (
      .bp(bp), .addr(addr), .locked(locked)
   );

   spi_wp_status u_status (
      .clk(clk), .rst_n(rst_n),
      .set_wel(cs_rise && pend == PD_WREN),
      .clr_wel(cs_rise && (pend == PD_WRDI || pend == PD_WRSR || pend == PD_WRITE)),
      .sr_load(cs_rise && pend == PD_WRSR),
      .sr_data(sr_buf),
      .wp_pin_n(wp_s),
      .wel(wel), .bp(bp), .status(status)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q <= 1'b0;
         cs_q <= 1'b1;
         phase <= ST_OPC;
         pend <= PD_NONE;
         bit_cnt <= '0;
         rx_sr <= '0;
         byte_cnt <= '0;
         rd_cmd <= 1'b0;
         adv <= 1'b0;
         addr <= '0;
         sr_buf <= '0;
         tx_sr <= '0;
         mem_we <= 1'b0;
         mem_wdata <= '0;
         spi_miso_oe <= 1'b0;
      end else begin
         sck_q <= sck_s;
         cs_q <= cs_s;
         mem_we <= 1'b0;
         adv <= 1'b0;
         spi_miso_oe <= !cs_s;
         if (adv) addr <= addr + 1'b1;
         if (cs_s) begin
            phase <= ST_OPC;
            pend <= PD_NONE;
            bit_cnt <= '0;
            byte_cnt <= '0;
         end else begin
            if (sck_rise) begin
               bit_cnt <= bit_cnt + 1'b1;
               rx_sr <= {rx_sr[5:0], mosi_s};
            end
            if (byte_done) begin
               unique case (phase)
                  ST_OPC: begin
                     unique case (rx_byte)
                        OP_WREN: begin pend <= PD_WREN; phase <= ST_HOLD; end
                        OP_WRDI: begin pend <= PD_WRDI; phase <= ST_HOLD; end
                        OP_RDSR: phase <= ST_STAT;
                        OP_WRSR: phase <= ST_SRW;
                        OP_READ: begin rd_cmd <= 1'b1; phase <= ST_ADDR; end
                        OP_WRITE: begin rd_cmd <= 1'b0; phase <= ST_ADDR; end
                        default: phase <= ST_HOLD;
                     endcase
                  end
                  ST_ADDR: begin
                     addr <= {addr[ADDR_W-9:0], rx_byte};
                     byte_cnt <= byte_cnt + 1'b1;
                     if (byte_cnt == BC_LAST) phase <= rd_cmd ? ST_RD : ST_WR;
                  end
                  ST_WR: begin
                     mem_we <= wel && !locked;
                     mem_wdata <= rx_byte;
                     pend <= PD_WRITE;
                     adv <= 1'b1;
                  end
                  ST_SRW: begin
                     sr_buf <= rx_byte;
                     pend <= PD_WRSR;
                     phase <= ST_HOLD;
                  end
                  default: ;
               endcase
            end
            if (sck_fall) begin
               if (bit_cnt == 3'd0 && (phase == ST_RD || phase == ST_STAT)) begin
                  tx_sr <= (phase == ST_RD) ? mem_rdata : status;
                  adv <= (phase == ST_RD);
               end else begin
                  tx_sr <= {tx_sr[6:0], 1'b0};
               end
            end
         end
      end
   end

   assign spi_miso = tx_sr[7];
   assign mem_addr = addr;

   // R6: no byte reaches memory unless the latch is armed
   a_r6_we_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> wel);
   // R6: one strobe per data byte
   a_r6_we_single: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we);
   // R9: output released while deselected
   a_r9_oe_idle: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s |=> !spi_miso_oe);
   // R6: a strobe never lands inside the fenced range
   a_r6_we_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> !locked);
endmodule

// File: tb/spi_wp_ctrl_test.sv
module spi_wp_ctrl_test;
   localparam int H = 8;
   localparam int AMASK = 32'h3FFFF;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic spi_cs_n = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0, wp_n = 1'b1;
   logic spi_miso, spi_miso_oe, mem_we;
   logic [17:0] mem_addr;
   logic [7:0] mem_wdata;
   logic [7:0] mem_rdata = 8'h00;

   always #10 clk = ~clk;

   spi_wp_ctrl uut (
      .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
      .spi_mosi(spi_mosi), .wp_n(wp_n), .spi_miso(spi_miso),
      .spi_miso_oe(spi_miso_oe), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   logic [7:0] mem [int];
   always @(posedge clk) begin
      if (mem_we) mem[int'(mem_addr)] = mem_wdata;
      mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00;
   end

   int nvec = 0, nerr = 0;
   logic m_wel = 1'b0, m_wpen = 1'b0;
   logic [1:0] m_bp = 2'b00;
   logic [7:0] exp_mem [int];
   bit done = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      nvec++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_status();
      return {m_wpen, 1'b1, 2'b00, m_bp, m_wel, 1'b0};
   endfunction

   function automatic bit prot(input int a, input logic [1:0] b);
      case (b)
         2'b00: return 0;
         2'b01: return a >= 32'h30000;
         2'b10: return a >= 32'h20000;
         default: return 1;
      endcase
   endfunction

   task automatic sbits(input logic [7:0] tx, input int n, output logic [7:0] rx);
      rx = '0;
      for (int i = 0; i < n; i++) begin
         spi_mosi = tx[7-i];
         repeat (H) @(negedge clk);
         rx = {rx[6:0], spi_miso};
         spi_sck = 1'b1;
         repeat (H) @(negedge clk);
         spi_sck = 1'b0;
      end
   endtask

   task automatic sbyte(input logic [7:0] tx, output logic [7:0] rx);
      sbits(tx, 8, rx);
   endtask

   task automatic cs_lo();
      spi_cs_n = 1'b0;
      repeat (H) @(negedge clk);
   endtask

   task automatic cs_hi();
      repeat (H) @(negedge clk);
      spi_cs_n = 1'b1;
      repeat (12) @(negedge clk);
      check(spi_miso_oe == 1'b0, "R9 oe idle", spi_miso_oe, 0);
   endtask

   task automatic cmd1(input logic [7:0] op);
      logic [7:0] r;
      cs_lo(); sbyte(op, r); cs_hi();
   endtask

   task automatic m_wren(); cmd1(8'h06); m_wel = 1'b1; endtask
   task automatic m_wrdi(); cmd1(8'h04); m_wel = 1'b0; endtask

   task automatic m_wrsr(input logic [7:0] d);
      logic [7:0] r;
      cs_lo(); sbyte(8'h01, r); sbyte(d, r); cs_hi();
      if (m_wel && !(m_wpen && !wp_n)) begin
         m_wpen = d[7];
         m_bp = d[3:2];
      end
      m_wel = 1'b0;
   endtask

   task automatic send_addr(input logic [7:0] op, input int a);
      logic [7:0] r;
      sbyte(op, r);
      sbyte(8'(a >> 16), r); sbyte(8'(a >> 8), r); sbyte(8'(a), r);
   endtask

   task automatic m_write(input int a, input int n);
      logic [7:0] r;
      int p = a;
      cs_lo(); send_addr(8'h02, a);
      for (int i = 0; i < n; i++) begin
         logic [7:0] d = 8'($urandom);
         sbyte(d, r);
         if (m_wel && !prot(p, m_bp)) exp_mem[p] = d;
         p = (p + 1) & AMASK;
      end
      cs_hi();
      if (n > 0) m_wel = 1'b0;
   endtask

   task automatic m_read(input int a, input int n, input string req);
      logic [7:0] r;
      int p = a;
      cs_lo(); send_addr(8'h03, a);
      for (int i = 0; i < n; i++) begin
         logic [7:0] e = exp_mem.exists(p) ? exp_mem[p] : 8'h00;
         sbyte(8'h00, r);
         check(r == e, req, r, e);
         p = (p + 1) & AMASK;
      end
      cs_hi();
   endtask

   task automatic m_rdsr(input string req);
      logic [7:0] r;
      cs_lo(); sbyte(8'h05, r);
      for (int i = 0; i < 2; i++) begin
         sbyte(8'hFF, r);
         check(r == exp_status(), req, r, exp_status());
      end
      cs_hi();
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         nerr++; nvec++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
         $finish;
      end
   end

   initial begin
      logic [7:0] r;
      void'($urandom(32'h5EED));
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check(spi_miso_oe == 1'b0 && mem_we == 1'b0, "R9 reset outputs", spi_miso_oe, 0);
      m_rdsr("R7 R1 reset status 40h");
      // R6: write with latch clear is dropped
      m_write(32'h00100, 2);
      m_read(32'h00100, 2, "R6 no latch no write");
      m_wren(); m_rdsr("R2 latch set");
      m_wrdi(); m_rdsr("R2 latch cleared");
      // R1 R3: fixed bits and latch bit ignored, latch cleared
      m_wren(); m_wrsr(8'hFF); m_rdsr("R1 R3 status after FFh");
      // R4: locked by pin
      wp_n = 1'b0;
      m_wren(); m_wrsr(8'h00); m_rdsr("R4 pin lock refuses write");
      wp_n = 1'b1;
      m_wren(); m_wrsr(8'h00); m_rdsr("R4 pin high allows write");
      wp_n = 1'b0;
      m_wren(); m_wrsr(8'h08); m_rdsr("R4 pin ignored when lock bit 0");
      wp_n = 1'b1;
      // R5: each fence setting, boundary bytes
      for (int b = 0; b < 4; b++) begin
         m_wren(); m_wrsr(8'(b << 2));
         m_wren(); m_write(32'h1FFFF, 2);
         m_wren(); m_write(32'h2FFFF, 2);
         m_read(32'h1FFFF, 2, "R5 half boundary");
         m_read(32'h2FFFF, 2, "R5 quarter boundary");
      end
      m_wren(); m_wrsr(8'h00);
      // R8: wrap
      m_wren(); m_write(32'h3FFFE, 4);
      m_read(32'h3FFFE, 4, "R8 wrap read");
      m_rdsr("R10 write clears latch");
      // R10: cut-short commands
      m_wren();
      cs_lo(); sbyte(8'h01, r); sbits(8'hFF, 4, r); cs_hi();
      m_rdsr("R10 partial status write no action");
      cs_lo(); send_addr(8'h02, 32'h00200); cs_hi();
      m_rdsr("R10 write without data keeps latch");
      // R11: unknown opcode swallows the rest
      cs_lo(); sbyte(8'hAB, r); sbyte(8'h04, r); cs_hi();
      m_rdsr("R11 unknown opcode keeps latch");
      m_wrdi();
      cs_lo(); sbyte(8'hAB, r); sbyte(8'h06, r); cs_hi();
      m_rdsr("R11 unknown opcode no enable");
      // random mix
      for (int it = 0; it < 70; it++) begin
         int op = $urandom % 7;
         int bases [4] = '{32'h1FFFE, 32'h2FFFE, 32'h3FFFD, 32'h0};
         int a = ($urandom % 2) ? bases[$urandom % 4] : ($urandom & AMASK);
         wp_n = ($urandom % 3) != 0;
         case (op)
            0: m_wren();
            1: m_wrdi();
            2: begin
               logic [7:0] d = 8'($urandom);
               if ($urandom % 2) d[7] = 1'b1;
               m_wrsr(d);
            end
            3, 4: begin
               int n = 1 + $urandom % 4;
               m_wren(); m_write(a, n); m_read(a, n, "R6 R5 random write");
            end
            5: m_rdsr("R7 random status");
            default: m_read(a, 3, "R8 random read");
         endcase
      end
      m_rdsr("R1 final status");
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end
endmodule